// File: doc/BRIEF.md
# Triggered ADC Acquisition Controller

This block is the device-side control for a four-channel, 16-bit sampling front end. A host programs it through a word-wide register port with offset addresses. The host sets a scan mode, a clock source and divisor, channel-group enables and power-down bits. It then starts acquisition by a software start strobe or by arming a hardware trigger input. While acquisition runs, a pacer produces one sample per sample period. The block steers the converter to the next channel of the scan and writes the returned sample into a FIFO.

The host drains the FIFO by reading the data offset or by DMA read strobes. A transfer counter decrements on every DMA pop. When it reaches zero, a sticky terminal-count flag is set, and an interrupt is raised if that interrupt is enabled. The flag stays set until the host writes the clear offset.

A status word reports the following: FIFO not empty, FIFO overflow, the offset-calibration busy window that follows release of digital power-down, interrupt pending, terminal count, and a fixed board ID. The converter itself, the analog filter and the host DMA engine sit outside the block.

Top module: `acq_ctrl`

Register offsets: 0 configuration, 1 trigger, 2 start, 3 FIFO flush, 4 sample data, 5 terminal-count clear, 6 status (read), 7 DMA control (bit 0 DMA enable, bit 1 terminal-count interrupt enable), 8 transfer count.

## Requirements
- R1: After reset, the status word reads `{6'b0, BOARD_ID, 8'h00}`, the configuration register reads 0 and `irq` is low.
- R2: Configuration bits [2:0] select the scan. Code 4+n samples only channel n. Code 2 alternates 0,1. Code 3 alternates 2,3. Code 1 cycles 0,1,2,3. Code 0 samples channel 0. Every start restarts the scan at its first channel.
- R3: The sample period is (CLK_BASE + cfg[4:3]) << cfg[6:5] cycles. In immediate mode, the first sample enters the FIFO one period after the start edge, and later samples follow once per period.
- R4: When trigger bit 4 is clear, a write to the start offset begins acquisition. When trigger bit 4 is set, a write to the trigger register arms the block instead: start writes are ignored, and a rising edge on `hw_trig` begins acquisition. Any trigger-register write also stops a running acquisition.
- R5: Trigger mode code 3 (bits [2:0]) discards 72 periods after the start, so the first sample arrives 73 periods after the start edge. Any other code captures at once.
- R6: When configuration bit 7 is clear, samples of channels 0 and 1 are stored as 0. When bit 8 is clear, samples of channels 2 and 3 are stored as 0.
- R7: While configuration bit 11 or bit 12 is set, the pacer halts and no sample is stored.
- R8: A configuration write that clears bit 12 while it was set raises status bit 5 for exactly CAL_CYCLES cycles.
- R9: Reading offset 4 returns the oldest sample unchanged (two's complement) and removes it. Status bit 0 is 1 exactly when the FIFO holds data.
- R10: With the FIFO full, new samples are dropped, the stored ones are kept, and status bit 3 stays set until a flush.
- R11: A write to offset 3 empties the FIFO, clears the overflow flag and returns the trigger logic to idle, so no further samples arrive.
- R12: Each `dma_rd` while the FIFO is non-empty pops one sample onto `dma_data`. With DMA enabled, it also decrements a non-zero transfer count. Reaching zero sets status bit 7. Status bit 6 and `irq` equal bit 7 AND the interrupt enable. A write to offset 5 clears bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops FIFO at offset 4) |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from offset |
| adc_chan | output | 2 | Channel the converter must present |
| adc_sample | input | DATA_W | Converter result for `adc_chan` |
| hw_trig | input | 1 | External start trigger, rising edge |
| dma_rd | input | 1 | DMA pop strobe |
| dma_data | output | DATA_W | FIFO head for DMA |
| irq | output | 1 | Terminal-count interrupt |

## Verification
The scan logic is driven with randomly drawn scan codes, clock selects, divisors, channel-group enables and sample counts. Each run is stopped after an exact number of periods. This shows whether channel order, group grounding and the period arithmetic all agree sample by sample. Directed starts then distinguish immediate from delayed capture by reading the not-empty flag exactly one cycle before and one cycle after the expected first sample. The same method separates software starts from hardware-armed starts. Filling past capacity, flushing, powered-down starts, DMA pops with the interrupt both enabled and masked, and the calibration window each isolate one flag and its clearing condition.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;
   localparam int NUM_CH = 4;
   localparam int CH_W   = 2;

   // register offsets
   localparam int OFS_CFG   = 0;
   localparam int OFS_TRIG  = 1;
   localparam int OFS_START = 2;
   localparam int OFS_FLUSH = 3;
   localparam int OFS_DATA  = 4;
   localparam int OFS_TCCLR = 5;
   localparam int OFS_STAT  = 6;
   localparam int OFS_DMA   = 7;
   localparam int OFS_XFER  = 8;

   // configuration fields
   localparam int CFG_SEL_LSB = 3;
   localparam int CFG_DIV_LSB = 5;
   localparam int CFG_EN_LO   = 7;
   localparam int CFG_EN_HI   = 8;
   localparam int CFG_APD     = 11;
   localparam int CFG_DPD     = 12;

   // trigger fields
   localparam int          TRG_HW      = 4;
   localparam logic [2:0]  TRG_DELAYED = 3'd3;

   // status bits
   localparam int ST_NE  = 0;
   localparam int ST_OVF = 3;
   localparam int ST_CAL = 5;
   localparam int ST_IRQ = 6;
   localparam int ST_TC  = 7;
   localparam int ST_ID  = 8;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ARMED = 2'd1,
      SEQ_DELAY = 2'd2,
      SEQ_RUN   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/acq_fifo.sv
`timescale 1ns/1ps
module acq_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic         ovf
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << AW));
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   initial begin : elab_chk
      assert (DEPTH >= 2) else $error("acq_fifo: DEPTH must be at least 2");
      assert (W >= 1) else $error("acq_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_pop, do_push;

   assign empty   = (cnt == '0);
   assign full    = (cnt == DEPTH_C);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = mem[rp];

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
         if (push && !do_push) ovf <= 1'b1;
      end
   end

   assert_pop_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push && !flush) |=> (cnt == $past(cnt) - 1'b1));
   assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= DEPTH_C);
   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !flush) |=> ovf);
   assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !ovf));
endmodule

// File: rtl/acq_sequencer.sv
`timescale 1ns/1ps
module acq_sequencer
   import acq_pkg::*;
#(
   parameter int CLK_BASE      = 4,
   parameter int DELAY_PERIODS = 72,
   parameter int SEL_W         = 2,
   parameter int DIV_W         = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic [DIV_W-1:0] clk_div,
   input  logic [2:0]       scan_code,
   input  logic [2:0]       trig_mode,
   input  logic             hw_sel,
   input  logic             trig_wr,
   input  logic             trig_wr_hw,
   input  logic             start_wr,
   input  logic             flush,
   input  logic             powered_down,
   input  logic             hw_trig,
   output logic             push,
   output logic [CH_W-1:0]  chan
);
   localparam int NSEL    = 1 << SEL_W;
   localparam int MAX_PER = (CLK_BASE + NSEL - 1) << ((1 << DIV_W) - 1);
   localparam int PER_W   = $clog2(MAX_PER + 1);
   localparam int DLY_W   = $clog2(DELAY_PERIODS + 1);

   initial begin : elab_chk
      assert (CLK_BASE >= 2) else $error("acq_sequencer: CLK_BASE must be at least 2");
      assert (DELAY_PERIODS >= 1) else $error("acq_sequencer: DELAY_PERIODS must be positive");
   end

   logic [PER_W-1:0] base_per [NSEL];
   logic [PER_W-1:0] period, pcnt;
   logic [DLY_W-1:0] dcnt;
   logic [CH_W-1:0]  idx;
   logic             hw_q, go, active, tick;
   seq_state_e       state;

   generate
      for (genvar g = 0; g < NSEL; g++) begin : g_base
         assign base_per[g] = PER_W'(CLK_BASE + g);
      end
   endgenerate

   assign period = base_per[clk_sel] << clk_div;
   assign go     = ((state == SEQ_IDLE) && start_wr && !hw_sel) ||
                   ((state == SEQ_ARMED) && hw_trig && !hw_q);
   assign active = ((state == SEQ_DELAY) || (state == SEQ_RUN)) && !powered_down;
   assign tick   = active && (pcnt >= period - 1'b1);
   assign push   = tick && (state == SEQ_RUN);

   always_comb begin
      case (scan_code)
         3'd1:    chan = idx;
         3'd2:    chan = {1'b0, idx[0]};
         3'd3:    chan = {1'b1, idx[0]};
         3'd4, 3'd5, 3'd6, 3'd7: chan = scan_code[1:0];
         default: chan = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         pcnt  <= '0;
         dcnt  <= '0;
         idx   <= '0;
         hw_q  <= 1'b0;
      end else begin
         hw_q <= hw_trig;
         if (flush) begin
            state <= SEQ_IDLE;
         end else if (trig_wr) begin
            state <= trig_wr_hw ? SEQ_ARMED : SEQ_IDLE;
         end else if (go) begin
            state <= (trig_mode == TRG_DELAYED) ? SEQ_DELAY : SEQ_RUN;
            pcnt  <= '0;
            dcnt  <= '0;
            idx   <= '0;
         end else if (active) begin
            if (tick) begin
               pcnt <= '0;
               if (state == SEQ_DELAY) begin
                  if (dcnt == DLY_W'(DELAY_PERIODS - 1)) state <= SEQ_RUN;
                  else dcnt <= dcnt + 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end else begin
               pcnt <= pcnt + 1'b1;
            end
         end
      end
   end

   assert_delay_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_DELAY) |-> !push);
   assert_armed_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == SEQ_ARMED) && start_wr && !hw_trig && !trig_wr && !flush) |=> (state == SEQ_ARMED));
endmodule

// File: rtl/acq_ctrl.sv
`timescale 1ns/1ps
module acq_ctrl
   import acq_pkg::*;
#(
   parameter int         DATA_W        = 16,
   parameter int         ADDR_W        = 4,
   parameter int         FIFO_DEPTH    = 16,
   parameter int         CLK_BASE      = 4,
   parameter int         DELAY_PERIODS = 72,
   parameter int         CAL_CYCLES    = 20,
   parameter int         XFER_W        = 16,
   parameter logic [1:0] BOARD_ID      = 2'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CH_W-1:0]   adc_chan,
   input  logic [DATA_W-1:0] adc_sample,
   input  logic              hw_trig,
   input  logic              dma_rd,
   output logic [DATA_W-1:0] dma_data,
   output logic              irq
);
   localparam int CAL_W = $clog2(CAL_CYCLES + 1);

   initial begin : elab_chk
      assert (DATA_W >= 16) else $error("acq_ctrl: DATA_W must hold all register fields");
      assert (ADDR_W >= 4) else $error("acq_ctrl: ADDR_W too small for offset map");
      assert (XFER_W <= DATA_W) else $error("acq_ctrl: XFER_W exceeds bus width");
      assert (CAL_CYCLES >= 2) else $error("acq_ctrl: CAL_CYCLES must be at least 2");
   end

   logic [DATA_W-1:0] cfg_q, trig_q, status, smp, fifo_head;
   logic [XFER_W-1:0] xfer_q;
   logic [CAL_W-1:0]  cal_cnt;
   logic              dma_en, tc_ie, tc_hit;
   logic              wr_cfg, wr_trig, wr_start, wr_flush, wr_tcclr, wr_dma, wr_xfer;
   logic              rd_data, dma_pop, pop, push, powered_down, grp_en;
   logic              fifo_empty, fifo_full, fifo_ovf, cal_busy;

   assign wr_cfg   = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
   assign wr_trig  = bus_wr && (bus_addr == ADDR_W'(OFS_TRIG));
   assign wr_start = bus_wr && (bus_addr == ADDR_W'(OFS_START));
   assign wr_flush = bus_wr && (bus_addr == ADDR_W'(OFS_FLUSH));
   assign wr_tcclr = bus_wr && (bus_addr == ADDR_W'(OFS_TCCLR));
   assign wr_dma   = bus_wr && (bus_addr == ADDR_W'(OFS_DMA));
   assign wr_xfer  = bus_wr && (bus_addr == ADDR_W'(OFS_XFER));
   assign rd_data  = bus_rd && (bus_addr == ADDR_W'(OFS_DATA));

   assign powered_down = cfg_q[CFG_APD] || cfg_q[CFG_DPD];
   assign grp_en       = adc_chan[1] ? cfg_q[CFG_EN_HI] : cfg_q[CFG_EN_LO];
   assign smp          = grp_en ? adc_sample : '0;
   assign dma_pop      = dma_rd && !fifo_empty;
   assign pop          = rd_data || dma_rd;
   assign cal_busy     = (cal_cnt != '0);
   assign irq          = tc_hit && tc_ie;
   assign dma_data     = fifo_head;

   acq_sequencer #(
      .CLK_BASE      (CLK_BASE),
      .DELAY_PERIODS (DELAY_PERIODS),
      .SEL_W         (2),
      .DIV_W         (2)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .clk_sel      (cfg_q[CFG_SEL_LSB +: 2]),
      .clk_div      (cfg_q[CFG_DIV_LSB +: 2]),
      .scan_code    (cfg_q[2:0]),
      .trig_mode    (trig_q[2:0]),
      .hw_sel       (trig_q[TRG_HW]),
      .trig_wr      (wr_trig),
      .trig_wr_hw   (bus_wdata[TRG_HW]),
      .start_wr     (wr_start),
      .flush        (wr_flush),
      .powered_down (powered_down),
      .hw_trig      (hw_trig),
      .push         (push),
      .chan         (adc_chan)
   );

   acq_fifo #(
      .W     (DATA_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (wr_flush),
      .push  (push),
      .din   (smp),
      .pop   (pop),
      .head  (fifo_head),
      .empty (fifo_empty),
      .full  (fifo_full),
      .ovf   (fifo_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         trig_q  <= '0;
         dma_en  <= 1'b0;
         tc_ie   <= 1'b0;
         xfer_q  <= '0;
         tc_hit  <= 1'b0;
         cal_cnt <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= bus_wdata;
         if (wr_trig) trig_q <= bus_wdata;
         if (wr_dma) begin
            dma_en <= bus_wdata[0];
            tc_ie  <= bus_wdata[1];
         end
         if (wr_xfer) xfer_q <= bus_wdata[XFER_W-1:0];
         else if (dma_en && dma_pop && (xfer_q != '0)) xfer_q <= xfer_q - 1'b1;
         if (wr_tcclr) tc_hit <= 1'b0;
         else if (dma_en && dma_pop && (xfer_q == XFER_W'(1)) && !wr_xfer) tc_hit <= 1'b1;
         if (wr_cfg && cfg_q[CFG_DPD] && !bus_wdata[CFG_DPD]) cal_cnt <= CAL_W'(CAL_CYCLES);
         else if (cal_busy) cal_cnt <= cal_cnt - 1'b1;
      end
   end

   always_comb begin
      status              = '0;
      status[ST_NE]       = !fifo_empty;
      status[ST_OVF]      = fifo_ovf;
      status[ST_CAL]      = cal_busy;
      status[ST_IRQ]      = irq;
      status[ST_TC]       = tc_hit;
      status[ST_ID +: 2]  = BOARD_ID;
   end

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_CFG):  bus_rdata = cfg_q;
         ADDR_W'(OFS_TRIG): bus_rdata = trig_q;
         ADDR_W'(OFS_DATA): bus_rdata = fifo_head;
         ADDR_W'(OFS_STAT): bus_rdata = status;
         ADDR_W'(OFS_DMA):  bus_rdata = DATA_W'({tc_ie, dma_en});
         ADDR_W'(OFS_XFER): bus_rdata = DATA_W'(xfer_q);
         default:           bus_rdata = '0;
      endcase
   end

   assert_no_sample_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !powered_down);
   assert_cal_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_busy && !wr_cfg) |=> (cal_cnt == $past(cal_cnt) - 1'b1));
   assert_tc_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tcclr |=> !tc_hit);
   assert_tc_at_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_hit) |-> (xfer_q == '0));
   assert_full_no_grow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !pop && !wr_flush) |=> fifo_full);
endmodule

// File: tb/tb_acq_ctrl.sv
`timescale 1ns/1ps
module tb_acq_ctrl;
   localparam int BASE  = 4;
   localparam int DLY   = 72;
   localparam int CAL   = 20;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata, adc_sample, dma_data;
   logic [1:0]  adc_chan;
   logic        hw_trig = 1'b0, dma_rd = 1'b0, irq;
   logic [15:0] salt = 16'h3C5A;
   int          n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   assign adc_sample = salt ^ (16'h1357 * {14'd0, adc_chan});

   acq_ctrl #(
      .DATA_W(16), .ADDR_W(4), .FIFO_DEPTH(DEPTH), .CLK_BASE(BASE),
      .DELAY_PERIODS(DLY), .CAL_CYCLES(CAL), .XFER_W(16), .BOARD_ID(2'd1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .adc_chan(adc_chan), .adc_sample(adc_sample), .hw_trig(hw_trig),
      .dma_rd(dma_rd), .dma_data(dma_data), .irq(irq)
   );

   function automatic logic [15:0] mk_cfg(int mode, int sel, int dv, bit e0, bit e1, bit apd, bit dpd);
      return 16'(mode) | 16'(sel << 3) | 16'(dv << 5) | 16'(e0 << 7) | 16'(e1 << 8)
             | 16'(apd << 11) | 16'(dpd << 12);
   endfunction

   function automatic int per_of(int sel, int dv);
      return (BASE + sel) << dv;
   endfunction

   function automatic int chan_of(int mode, int j);
      case (mode)
         1: return j % 4;
         2: return j % 2;
         3: return 2 + (j % 2);
         4, 5, 6, 7: return mode - 4;
         default: return 0;
      endcase
   endfunction

   function automatic logic [15:0] val_of(int ch, bit e0, bit e1);
      bit en = (ch < 2) ? e0 : e1;
      return en ? (salt ^ (16'h1357 * 16'(ch))) : 16'h0000;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      bus_addr = 4'(a); bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic dma_pop(output logic [15:0] d);
      dma_rd = 1'b1;
      #1 d = dma_data;
      @(negedge clk);
      dma_rd = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [15:0] d;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(6, d); chk("R1 status", d, 16'h0100);
      rd(0, d); chk("R1 cfg", d, 16'h0000);
      chk("R1 irq", irq, 0);

      // R8 calibration window
      wr(0, mk_cfg(4, 0, 0, 1, 1, 0, 1));
      wr(0, mk_cfg(4, 0, 0, 1, 1, 0, 0));
      rd(6, d); chk("R8 cal busy first", d[5], 1);
      idle(CAL - 2);
      rd(6, d); chk("R8 cal busy last", d[5], 1);
      rd(6, d); chk("R8 cal clear", d[5], 0);

      // R3 first-sample timing, immediate mode
      wr(1, 16'h0002);
      wr(0, mk_cfg(4, 1, 1, 1, 1, 0, 0));
      wr(2, 16'h0000);
      idle(per_of(1, 1) - 1);
      rd(6, d); chk("R3 before first sample", d[0], 0);
      rd(6, d); chk("R3 at first sample", d[0], 1);
      wr(3, 16'h0000);

      // R5 delayed start
      wr(1, 16'h0003);
      wr(0, mk_cfg(5, 0, 0, 1, 1, 0, 0));
      wr(2, 16'h0000);
      idle(73 * per_of(0, 0) - 1);
      rd(6, d); chk("R5 before delayed sample", d[0], 0);
      rd(6, d); chk("R5 delayed sample", d[0], 1);
      wr(1, 16'h0002);
      wr(3, 16'h0000);

      // R4 hardware trigger: start ignored while armed
      wr(1, 16'h0012);
      wr(2, 16'h0000);
      idle(3 * per_of(0, 0));
      rd(6, d); chk("R4 start ignored when armed", d[0], 0);
      hw_trig = 1'b1;
      @(negedge clk);
      idle(per_of(0, 0) - 1);
      rd(6, d); chk("R4 hw before sample", d[0], 0);
      rd(6, d); chk("R4 hw sample", d[0], 1);
      hw_trig = 1'b0;
      wr(1, 16'h0002);
      wr(3, 16'h0000);

      // R6 directed: group 2/3 grounded, full scan
      wr(0, mk_cfg(1, 0, 0, 1, 0, 0, 0));
      wr(2, 16'h0000);
      idle(4 * per_of(0, 0) - 1);
      wr(1, 16'h0002);
      for (int j = 0; j < 4; j++) begin
         rd(4, d); chk($sformatf("R6 grounded group sample %0d", j), d, val_of(j, 1, 0));
      end

      // R2 R6 R9 randomized scans
      for (int it = 0; it < 10; it++) begin
         int mode, sel, dv, k, p;
         bit e0, e1;
         mode = $urandom_range(0, 7);
         sel  = $urandom_range(0, 3);
         dv   = $urandom_range(0, 2);
         e0   = 1'($urandom_range(0, 1));
         e1   = 1'($urandom_range(0, 1));
         k    = $urandom_range(1, 12);
         salt = 16'($urandom);
         p    = per_of(sel, dv);
         wr(0, mk_cfg(mode, sel, dv, e0, e1, 0, 0));
         wr(2, 16'h0000);
         idle(k * p - 1);
         wr(1, 16'h0002);
         for (int j = 0; j < k; j++) begin
            rd(4, d);
            chk($sformatf("R2 R6 R9 mode %0d sample %0d", mode, j), d, val_of(chan_of(mode, j), e0, e1));
         end
         rd(6, d); chk("R9 empty after drain", d[0], 0);
      end

      // R10 overflow
      salt = 16'h7E01;
      wr(0, mk_cfg(5, 0, 0, 1, 1, 0, 0));
      wr(2, 16'h0000);
      idle((DEPTH + 4) * per_of(0, 0) - 1);
      wr(1, 16'h0002);
      rd(6, d); chk("R10 ovf set", d[3], 1);
      for (int j = 0; j < DEPTH; j++) begin
         rd(4, d); chk($sformatf("R10 kept sample %0d", j), d, val_of(1, 1, 1));
      end
      rd(6, d); chk("R10 drained", d[0], 0);
      chk("R10 ovf sticky", d[3], 1);
      wr(3, 16'h0000);
      rd(6, d); chk("R11 ovf cleared by flush", d[3], 0);

      // R11 flush stops acquisition
      wr(2, 16'h0000);
      idle(3 * per_of(0, 0));
      wr(3, 16'h0000);
      rd(6, d); chk("R11 empty after flush", d[0], 0);
      idle(3 * per_of(0, 0));
      rd(6, d); chk("R11 stays idle", d[0], 0);

      // R7 power-down halts pacer
      wr(0, mk_cfg(4, 0, 0, 1, 1, 1, 0));
      wr(2, 16'h0000);
      idle(5 * per_of(0, 0));
      rd(6, d); chk("R7 no samples when powered down", d[0], 0);
      wr(1, 16'h0002);

      // R12 terminal count with interrupt enabled
      salt = 16'h9A4B;
      wr(0, mk_cfg(4, 0, 0, 1, 1, 0, 0));
      wr(2, 16'h0000);
      idle(5 * per_of(0, 0) - 1);
      wr(1, 16'h0002);
      wr(8, 16'd3);
      wr(7, 16'h0003);
      dma_pop(d); chk("R12 dma data 0", d, val_of(0, 1, 1));
      dma_pop(d); chk("R12 dma data 1", d, val_of(0, 1, 1));
      rd(6, d); chk("R12 tc not yet", d[7], 0);
      dma_pop(d);
      rd(6, d); chk("R12 tc flag", d[7], 1);
      chk("R12 irq pending bit", d[6], 1);
      chk("R12 irq port", irq, 1);
      wr(5, 16'h0000);
      rd(6, d); chk("R12 tc cleared", d[7], 0);
      chk("R12 irq dropped", irq, 0);

      // R12 terminal count with interrupt masked
      wr(7, 16'h0001);
      wr(8, 16'd1);
      dma_pop(d);
      rd(6, d); chk("R12 tc masked flag", d[7], 1);
      chk("R12 masked pending bit", d[6], 0);
      chk("R12 masked irq port", irq, 0);
      wr(5, 16'h0000);
      wr(3, 16'h0000);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule